// File: doc/BRIEF.md
# Multimode Audio Serial Port Receiver

This block is the receive side of a synchronous audio serial port. It runs entirely in the bit-clock domain and samples one serial data line on each rising bit-clock edge. A frame-sync input marks word and frame boundaries. The frame sync comes from either an internal or an external source, picked by a select bit. One shift path serves four framing modes:

- single-word DSP framing
- left-justified sample pairs
- I2S
- multichannel TDM

Word length and bit order are programmable. Each captured word leaves the block as a 32-bit value, right-aligned and sign-extended. It carries a one-cycle valid strobe, a slot index and a left/right tag.

A frame sync that arrives while a word is only partly shifted in is a framing fault. The block drops the partial word, starts capturing a new word at once, and latches a sticky error flag. Software clears the flag by writing one to it. In TDM mode a per-slot enable mask lets unused slots pass through the shifter without producing output.

Top module: `aud_srx`

## Requirements
- R1: Mode encoding on `cfg_mode` is 0 = single-word framing, 1 = left-justified pair, 2 = I2S, 3 = TDM. In mode 0, each rising edge of the selected frame sync starts one word, and the data bit sampled on that same clock is the first bit. The word holds `cfg_wlen`+1 bits and is reported with slot 0 and `rx_right` = 0.
- R2: With `cfg_lsb_first` = 0 the first received bit is the word's most significant bit. With `cfg_lsb_first` = 1 it is bit 0.
- R3: `rx_data` holds the word right-aligned in 32 bits. Every bit above the word's top bit is a copy of that top bit.
- R4: `cfg_wlen` is the word length minus one. In modes 0 and 3, values below 2 act as 2, giving 3 bits. In modes 1 and 2, values below 7 act as 7, giving 8 bits.
- R5: In mode 1, every change of frame sync starts a word whose first bit is sampled on the clock where the change is first seen. The word that starts on a rise is left (`rx_right` = 0); the one that starts on a fall is right (`rx_right` = 1).
- R6: In mode 2, the first bit is sampled one clock after the clock where the frame-sync change is seen. The bit on the change clock is ignored. Frame sync low marks left (`rx_right` = 0) and high marks right (`rx_right` = 1).
- R7: In mode 3, a frame-sync rise starts slot 0. Slots then follow back to back with no gap, numbered up to `cfg_nslots` (at most 128 slots). After the last slot the receiver idles until the next rise.
- R8: In mode 3, a slot whose bit in `cfg_slot_mask` is 0 is shifted in but never raises `rx_valid`.
- R9: `rx_valid` is high for exactly one cycle, in the cycle after the clock that sampled a word's last bit. In that cycle `rx_slot` gives the slot of that word.
- R10: A word start that occurs while an earlier word is partly received sets `err_early`. The flag stays set, the partial word is discarded, and the new word is captured in full.
- R11: Driving `err_clr` high for one clock clears `err_early`. If an early start occurs on that same clock, the flag stays set.
- R12: `cfg_fs_ext` = 1 takes the frame sync from `fs_ext`. `cfg_fs_ext` = 0 takes it from `fs_int`. The input that is not selected has no effect.
- R13: After reset `rx_valid`, `err_early` and `rx_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; data sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Framing mode select |
| cfg_wlen | input | 5 | Word length minus one |
| cfg_lsb_first | input | 1 | Bit order: 1 = least significant bit first |
| cfg_fs_ext | input | 1 | Frame sync source: 1 = external |
| cfg_nslots | input | 7 | Last TDM slot index |
| cfg_slot_mask | input | 128 | Per-slot output enable in TDM |
| fs_int | input | 1 | Internally generated frame sync |
| fs_ext | input | 1 | Externally supplied frame sync |
| sd | input | 1 | Serial data |
| err_clr | input | 1 | Write-one-to-clear for the error flag |
| rx_data | output | 32 | Captured word, sign-extended |
| rx_valid | output | 1 | One-cycle word strobe |
| rx_slot | output | 7 | Slot index of the word |
| rx_right | output | 1 | Right-channel tag |
| err_early | output | 1 | Sticky early frame-sync flag |

## Verification
The hardest situations to reach are the ones where framing is deliberately broken.

The first is a frame sync that lands in the middle of a word. The stimulus issues a second frame-sync rise a few bits into a word. It then checks three things: the flag rises, exactly one word comes out, and that word carries the new data rather than a mix of old and new bits.

The second is an early start that coincides with a clear request on the same clock. To reach it, the bench holds `err_clr` high on precisely the bit clock that carries the early rise.

The I2S one-bit offset is checked by driving a one on the change clock, a bit that must not enter the word.

// File: rtl/aud_srx_pkg.sv
package aud_srx_pkg;
  typedef enum logic [1:0] {
    MODE_STD = 2'd0,
    MODE_LJP = 2'd1,
    MODE_I2S = 2'd2,
    MODE_TDM = 2'd3
  } srx_mode_e;
endpackage

// File: rtl/aud_srx_frame.sv
// Frame-sync selection, edge detection and per-mode word-start decode.
module aud_srx_frame
  import aud_srx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       fs_ext_sel,
  input  logic       fs_int,
  input  logic       fs_ext,
  output logic       frm_start,
  output logic       frm_right
);
  logic fs_sel, fs_q, edge_q;
  logic rise, fall;

  always_comb begin
    fs_sel = fs_ext_sel ? fs_ext : fs_int;
    rise   = fs_sel & ~fs_q;
    fall   = ~fs_sel & fs_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_q   <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      fs_q   <= fs_sel;
      edge_q <= rise | fall;
    end
  end

  always_comb begin
    frm_start = 1'b0;
    frm_right = 1'b0;
    case (srx_mode_e'(mode))
      MODE_LJP: begin
        frm_start = rise | fall;
        frm_right = fall;
      end
      MODE_I2S: begin
        // word select change seen one clock earlier; level now in fs_q
        frm_start = edge_q;
        frm_right = fs_q;
      end
      default: begin
        frm_start = rise;
        frm_right = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/aud_srx_shift.sv
// Bit counter, shift register, sign extension and early-start detection.
module aud_srx_shift #(
  parameter int DW = 32,
  localparam int LW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          sd,
  input  logic          lsb_first,
  input  logic [LW-1:0] wlen,
  output logic          done,
  output logic          early,
  output logic [DW-1:0] word
);
  logic [DW-1:0] sh, sh_nxt;
  logic [LW-1:0] cnt, cnt_nxt;
  logic          act, act_nxt;
  logic          en;

  always_comb begin
    sh_nxt  = sh;
    cnt_nxt = cnt;
    act_nxt = act;
    done    = 1'b0;
    early   = start & act;
    if (start) begin
      sh_nxt    = '0;
      sh_nxt[0] = sd;
      cnt_nxt   = LW'(1);
      act_nxt   = 1'b1;
    end else if (act) begin
      if (lsb_first) sh_nxt[cnt] = sd;
      else           sh_nxt = {sh[DW-2:0], sd};
      if (cnt == wlen) begin
        done    = 1'b1;
        act_nxt = 1'b0;
        cnt_nxt = '0;
      end else begin
        cnt_nxt = cnt + LW'(1);
      end
    end
  end

  assign en = start | act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
      act <= 1'b0;
    end else if (en) begin
      sh  <= sh_nxt;
      cnt <= cnt_nxt;
      act <= act_nxt;
    end
  end

  for (genvar g = 0; g < DW; g++) begin : g_sx
    assign word[g] = (LW'(g) <= wlen) ? sh_nxt[g] : sh_nxt[wlen];
  end
endmodule

// File: rtl/aud_srx_slot.sv
// Slot sequencing: tag and index of the current word, TDM back-to-back restarts.
module aud_srx_slot #(
  parameter int SLOTS = 128,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tdm,
  input  logic             frm_start,
  input  logic             frm_right,
  input  logic             done,
  input  logic [SW-1:0]    nslots,
  input  logic [SLOTS-1:0] mask,
  output logic             word_start,
  output logic [SW-1:0]    wslot,
  output logic             wright,
  output logic             slot_en
);
  logic          cont_q, cont_nxt;
  logic [SW-1:0] wslot_nxt;
  logic          wright_nxt;

  always_comb begin
    word_start = frm_start | cont_q;
    cont_nxt   = done & tdm & (wslot != nslots);
    wslot_nxt  = wslot;
    wright_nxt = wright;
    if (frm_start) begin
      wslot_nxt  = '0;
      wright_nxt = frm_right;
    end else if (cont_q) begin
      wslot_nxt  = wslot + SW'(1);
      wright_nxt = 1'b0;
    end
    slot_en = tdm ? mask[wslot] : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cont_q <= 1'b0;
      wslot  <= '0;
      wright <= 1'b0;
    end else begin
      cont_q <= cont_nxt;
      if (word_start) begin
        wslot  <= wslot_nxt;
        wright <= wright_nxt;
      end
    end
  end
endmodule

// File: rtl/aud_srx.sv
module aud_srx
  import aud_srx_pkg::*;
#(
  parameter int DW = 32,
  parameter int SLOTS = 128,
  localparam int LW = $clog2(DW),
  localparam int SW = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mode,
  input  logic [LW-1:0]    cfg_wlen,
  input  logic             cfg_lsb_first,
  input  logic             cfg_fs_ext,
  input  logic [SW-1:0]    cfg_nslots,
  input  logic [SLOTS-1:0] cfg_slot_mask,
  input  logic             fs_int,
  input  logic             fs_ext,
  input  logic             sd,
  input  logic             err_clr,
  output logic [DW-1:0]    rx_data,
  output logic             rx_valid,
  output logic [SW-1:0]    rx_slot,
  output logic             rx_right,
  output logic             err_early
);
  localparam logic [LW-1:0] MIN_AUD = LW'(7);
  localparam logic [LW-1:0] MIN_STD = LW'(2);

  logic          frm_start, frm_right, word_start, wright, slot_en;
  logic          done, early_det, tdm, aud;
  logic [SW-1:0] wslot;
  logic [DW-1:0] word;
  logic [LW-1:0] wlen_eff;
  logic          take;
  logic          valid_nxt, right_nxt, err_nxt;
  logic [DW-1:0] data_nxt;
  logic [SW-1:0] slot_nxt;

  always_comb begin
    tdm = (srx_mode_e'(cfg_mode) == MODE_TDM);
    aud = (srx_mode_e'(cfg_mode) == MODE_LJP) || (srx_mode_e'(cfg_mode) == MODE_I2S);
    if (aud) wlen_eff = (cfg_wlen < MIN_AUD) ? MIN_AUD : cfg_wlen;
    else     wlen_eff = (cfg_wlen < MIN_STD) ? MIN_STD : cfg_wlen;
  end

  aud_srx_frame u_frame (
    .clk(clk), .rst_n(rst_n), .mode(cfg_mode), .fs_ext_sel(cfg_fs_ext),
    .fs_int(fs_int), .fs_ext(fs_ext), .frm_start(frm_start), .frm_right(frm_right)
  );

  aud_srx_slot #(.SLOTS(SLOTS)) u_slot (
    .clk(clk), .rst_n(rst_n), .tdm(tdm), .frm_start(frm_start), .frm_right(frm_right),
    .done(done), .nslots(cfg_nslots), .mask(cfg_slot_mask), .word_start(word_start),
    .wslot(wslot), .wright(wright), .slot_en(slot_en)
  );

  aud_srx_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(word_start), .sd(sd), .lsb_first(cfg_lsb_first),
    .wlen(wlen_eff), .done(done), .early(early_det), .word(word)
  );

  always_comb begin
    take      = done & slot_en;
    valid_nxt = take;
    data_nxt  = take ? word : rx_data;
    slot_nxt  = take ? wslot : rx_slot;
    right_nxt = take ? wright : rx_right;
    err_nxt   = early_det | (err_early & ~err_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid  <= 1'b0;
      rx_data   <= '0;
      rx_slot   <= '0;
      rx_right  <= 1'b0;
      err_early <= 1'b0;
    end else begin
      rx_valid  <= valid_nxt;
      rx_data   <= data_nxt;
      rx_slot   <= slot_nxt;
      rx_right  <= right_nxt;
      err_early <= err_nxt;
    end
  end
endmodule

// File: rtl/aud_srx_chk.sv
module aud_srx_chk #(
  parameter int DW = 32,
  parameter int SLOTS = 128,
  localparam int LW = $clog2(DW),
  localparam int SW = $clog2(SLOTS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cfg_mode,
  input logic [LW-1:0]    cfg_wlen,
  input logic [SW-1:0]    cfg_nslots,
  input logic [SLOTS-1:0] cfg_slot_mask,
  input logic             err_clr,
  input logic             early,
  input logic             rx_valid,
  input logic [DW-1:0]    rx_data,
  input logic [SW-1:0]    rx_slot,
  input logic             rx_right,
  input logic             err_early
);
  a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r10_early_sets: assert property (@(posedge clk) disable iff (!rst_n)
    early |=> err_early);

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_early && !err_clr) |=> err_early);

  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !early) |=> !err_early);

  a_r8_masked_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cfg_mode == 2'd3) |-> cfg_slot_mask[rx_slot]);

  a_r7_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cfg_mode == 2'd3) |-> (rx_slot <= cfg_nslots));

  a_r1_std_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cfg_mode == 2'd0) |-> (rx_slot == '0 && !rx_right));

  a_r3_sext16: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cfg_wlen == LW'(15)) |-> (rx_data[DW-1:16] == {(DW-16){rx_data[15]}}));
endmodule

bind aud_srx aud_srx_chk #(.DW(DW), .SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_wlen(cfg_wlen),
  .cfg_nslots(cfg_nslots), .cfg_slot_mask(cfg_slot_mask), .err_clr(err_clr),
  .early(early_det), .rx_valid(rx_valid), .rx_data(rx_data), .rx_slot(rx_slot),
  .rx_right(rx_right), .err_early(err_early)
);

// File: tb/aud_srx_bench.sv
module aud_srx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;

  localparam logic [4:0]  V_WL  [NV] = '{5'd15, 5'd15, 5'd31, 5'd2, 5'd0, 5'd23, 5'd7};
  localparam logic        V_LSB [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
  localparam int          V_N   [NV] = '{16, 16, 32, 3, 3, 24, 8};
  localparam logic [31:0] V_W   [NV] = '{32'hA5C3, 32'h1234, 32'h8000_0001, 32'h5,
                                          32'h3, 32'h80_0F0F, 32'h7E};
  localparam logic [31:0] V_EXP [NV] = '{32'hFFFF_A5C3, 32'h0000_1234, 32'h8000_0001,
                                          32'hFFFF_FFFD, 32'h0000_0003, 32'hFF80_0F0F,
                                          32'h0000_007E};

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0]   cfg_mode;
  logic [4:0]   cfg_wlen;
  logic         cfg_lsb_first, cfg_fs_ext;
  logic [6:0]   cfg_nslots;
  logic [127:0] cfg_slot_mask;
  logic fs_int, fs_ext, sd, err_clr;
  logic [31:0]  rx_data;
  logic         rx_valid, rx_right, err_early;
  logic [6:0]   rx_slot;

  int n_chk = 0, n_bad = 0, vcount = 0;

  aud_srx u_aud_srx (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_wlen(cfg_wlen),
    .cfg_lsb_first(cfg_lsb_first), .cfg_fs_ext(cfg_fs_ext), .cfg_nslots(cfg_nslots),
    .cfg_slot_mask(cfg_slot_mask), .fs_int(fs_int), .fs_ext(fs_ext), .sd(sd),
    .err_clr(err_clr), .rx_data(rx_data), .rx_valid(rx_valid), .rx_slot(rx_slot),
    .rx_right(rx_right), .err_early(err_early)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input logic fi, input logic fe, input logic d, input logic c);
    @(negedge clk);
    fs_int = fi; fs_ext = fe; sd = d; err_clr = c;
    @(posedge clk);
    #1;
    if (rx_valid) vcount++;
  endtask

  // n bits of w; fs level on first bit and on the rest; ext picks the fs pin
  task automatic send(input logic [31:0] w, input int n, input bit lsb,
                      input bit fs0, input bit fsr, input bit ext);
    for (int k = 0; k < n; k++) begin
      logic b, f;
      b = lsb ? w[k] : w[n-1-k];
      f = (k == 0) ? fs0 : fsr;
      tick(ext ? 1'b0 : f, ext ? f : 1'b0, b, 1'b0);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) tick(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v0;
    rst_n = 1'b0; cfg_mode = 2'd0; cfg_wlen = 5'd15; cfg_lsb_first = 1'b0;
    cfg_fs_ext = 1'b0; cfg_nslots = 7'd0; cfg_slot_mask = '0;
    fs_int = 1'b0; fs_ext = 1'b0; sd = 1'b0; err_clr = 1'b0;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(rx_valid == 1'b0, "R13 valid", 32'(rx_valid), 0);
    chk(err_early == 1'b0, "R13 err", 32'(err_early), 0);
    chk(rx_data == 32'h0, "R13 data", rx_data, 0);
    rst_n = 1'b1;
    idle(2);

    // R1 R2 R3 R4 table of single-word frames
    for (int i = 0; i < NV; i++) begin
      cfg_wlen = V_WL[i]; cfg_lsb_first = V_LSB[i];
      v0 = vcount;
      send(V_W[i], V_N[i], V_LSB[i], 1'b1, 1'b0, 1'b0);
      chk(rx_valid && rx_data == V_EXP[i] && rx_slot == 0 && !rx_right,
          "R1/R2/R3/R4 word", rx_data, V_EXP[i]);
      idle(3);
      chk(vcount == v0 + 1, "R9 single strobe", 32'(vcount - v0), 1);
    end

    // R12 source select: fs_int ignored when external chosen
    cfg_fs_ext = 1'b1; cfg_wlen = 5'd15; cfg_lsb_first = 1'b0;
    v0 = vcount;
    send(32'hFFFF, 16, 1'b0, 1'b1, 1'b0, 1'b0);
    idle(4);
    chk(vcount == v0, "R12 unselected fs", 32'(vcount - v0), 0);
    send(32'h6E01, 16, 1'b0, 1'b1, 1'b0, 1'b1);
    chk(rx_valid && rx_data == 32'h6E01, "R12 selected fs", rx_data, 32'h6E01);
    cfg_fs_ext = 1'b0;
    idle(2);

    // R5 left-justified pairs
    cfg_mode = 2'd1;
    send(32'hC001, 16, 1'b0, 1'b1, 1'b1, 1'b0);
    chk(rx_valid && !rx_right && rx_data == 32'hFFFF_C001, "R5 left", rx_data, 32'hFFFF_C001);
    send(32'h2468, 16, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(rx_valid && rx_right && rx_data == 32'h2468, "R5 right", rx_data, 32'h2468);
    // R4 clamp in audio mode: wlen 3 acts as 8 bits
    cfg_wlen = 5'd3;
    send(32'hC3, 8, 1'b0, 1'b1, 1'b1, 1'b0);
    chk(rx_valid && !rx_right && rx_data == 32'hFFFF_FFC3, "R4 audio clamp L", rx_data, 32'hFFFF_FFC3);
    send(32'h5A, 8, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(rx_valid && rx_right && rx_data == 32'h5A, "R4 audio clamp R", rx_data, 32'h5A);
    idle(2);

    // R6 I2S: bit on the change clock is driven 1 and must be ignored
    cfg_mode = 2'd2; cfg_wlen = 5'd15;
    tick(1'b1, 1'b0, 1'b1, 1'b0);
    send(32'h4321, 16, 1'b0, 1'b1, 1'b1, 1'b0);
    chk(rx_valid && rx_right && rx_data == 32'h4321, "R6 right offset", rx_data, 32'h4321);
    tick(1'b0, 1'b0, 1'b1, 1'b0);
    send(32'h8001, 16, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(rx_valid && !rx_right && rx_data == 32'hFFFF_8001, "R6 left offset", rx_data, 32'hFFFF_8001);
    idle(2);

    // R7 R8 TDM: 4 slots of 8 bits, slot 2 masked off
    cfg_mode = 2'd3; cfg_wlen = 5'd7; cfg_nslots = 7'd3; cfg_slot_mask = 128'hB;
    send(32'h81, 8, 1'b0, 1'b1, 1'b0, 1'b0);
    chk(rx_valid && rx_slot == 0 && rx_data == 32'hFFFF_FF81, "R7 slot0", rx_data, 32'hFFFF_FF81);
    send(32'h12, 8, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(rx_valid && rx_slot == 1 && rx_data == 32'h12, "R7 slot1", rx_data, 32'h12);
    send(32'hF0, 8, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(!rx_valid, "R8 masked slot", 32'(rx_valid), 0);
    send(32'h3C, 8, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(rx_valid && rx_slot == 3 && rx_data == 32'h3C, "R7 slot3", rx_data, 32'h3C);
    v0 = vcount;
    send(32'hFF, 8, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(vcount == v0, "R7 idle after last slot", 32'(vcount - v0), 0);
    chk(err_early == 1'b0, "R10 no false flag", 32'(err_early), 0);
    idle(2);

    // R10 early frame sync in single-word mode
    cfg_mode = 2'd0; cfg_wlen = 5'd15;
    v0 = vcount;
    send(32'hFFFF, 5, 1'b0, 1'b1, 1'b0, 1'b0);
    chk(err_early == 1'b0, "R10 before early", 32'(err_early), 0);
    send(32'h0F0F, 16, 1'b0, 1'b1, 1'b0, 1'b0);
    chk(err_early == 1'b1, "R10 flag set", 32'(err_early), 1);
    chk(rx_valid && rx_data == 32'h0F0F, "R10 new word kept", rx_data, 32'h0F0F);
    idle(3);
    chk(vcount == v0 + 1, "R10 partial dropped", 32'(vcount - v0), 1);
    chk(err_early == 1'b1, "R10 sticky", 32'(err_early), 1);

    // R11 clear, and set beats clear
    tick(1'b0, 1'b0, 1'b0, 1'b1);
    chk(err_early == 1'b0, "R11 clear", 32'(err_early), 0);
    send(32'h7, 3, 1'b0, 1'b1, 1'b0, 1'b0);
    tick(1'b1, 1'b0, 1'b0, 1'b1);
    chk(err_early == 1'b1, "R11 set wins", 32'(err_early), 1);
    idle(18);
    tick(1'b0, 1'b0, 1'b0, 1'b1);
    chk(err_early == 1'b0, "R11 clear again", 32'(err_early), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule